// File: doc/BRIEF.md
# Three-Section Tone Prefilter

This block cleans up audio samples for a frequency-shift-keyed receiver before they reach a one-bit slicer. It takes 8-bit unsigned samples on a sample strobe, about 8 kHz in use, and moves them to a signed scale centred on zero. It then passes them through three cascaded second-order recursive bandpass sections that use only small integer gains and shift-right-by-three scaling.

A single role input picks the passband. With the role low (answer side) the sections centre near 1170 Hz. With the role high (originate side) they centre near 2125 Hz. The two settings differ only in the weight on the previous output. The block presents the sign of the last section as a bit and also exposes the last section's signed value for inspection.

All three sections settle in the same clock cycle as the strobe. The results are registered on that edge.

Top module: `tone_prefilter`

## Requirements
- R1: The raw sample is converted to a signed value equal to raw minus 128, so raw 128 maps to 0, raw 0 maps to -128 and raw 255 maps to +127.
- R2: The feed-forward term of section k is g_k times (u[n] - u[n-2]), where u is that section's input. The gains are g = 8, 3 and 2 in cascade order. The first section's input is the centred sample, and each later section's input is the previous section's output of the same strobe.
- R3: With role_orig = 0, each section computes y[n] = floor((ff + 7*y[n-1] - 4*y[n-2]) / 8), where the divide by 8 is an arithmetic right shift by 3 on two's complement values.
- R4: With role_orig = 1, each section uses -1 in place of 7 as the weight on y[n-1]. The -4 weight on y[n-2] and the shift by 3 stay the same.
- R5: bit_out is 1 when filt_out is zero or positive, and 0 when filt_out is negative.
- R6: When smp_stb is low, smp_raw and role_orig are ignored. No history moves and both outputs hold their values.
- R7: role_orig is sampled on each strobe, so a change of role applies from the next strobe. It does not clear any history.
- R8: A synchronous active-high reset clears every input and output history in all sections, sets filt_out to 0 and sets bit_out to 1.
- R9: filt_out and bit_out take the new result at the clock edge where smp_stb is high, and show it from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| smp_raw | input | IN_W (8) | Unsigned sample, mid-scale at 128 |
| role_orig | input | 1 | 0 selects the answer-side passband, 1 the originate-side passband |
| bit_out | output | 1 | Sliced sign of the last section's output |
| filt_out | output | ACC_W (18) | Signed output of the last section |

## Verification
Four things are checked on every cycle:
- The sliced bit always agrees with the sign of the filtered value.
- Both outputs stay frozen in any cycle without a strobe.
- The outputs hold their cleared values right after reset.
- The first strobe after reset gives the closed-form response of the cascade from empty history.

The recursion itself needs the bench's reference model to be seen. That covers the two feedback weights, role switching in the middle of a stream with history kept, and the floor behaviour of the shift on negative sums. The bench drives tones, impulses, full-scale extremes and random streams with random gaps and random role flips.

// File: rtl/tone_bpf_pkg.sv
package tone_bpf_pkg;

    typedef enum logic {
        ROLE_ANSWER    = 1'b0,
        ROLE_ORIGINATE = 1'b1
    } role_e;

    localparam int NUM_SECT  = 3;
    localparam int SCALE_SH  = 3;
    localparam int FB_LAG2   = -4;
    localparam int HEADROOM  = 6;

    // feed-forward gain on the two-step difference, per cascade position
    function automatic int sect_gain(input int idx);
        case (idx)
            0:       return 8;
            1:       return 3;
            default: return 2;
        endcase
    endfunction

    // weight on the previous output; the only term that retunes the passband
    function automatic int lag1_weight(input role_e role);
        return (role == ROLE_ORIGINATE) ? -1 : 7;
    endfunction

endpackage

// File: rtl/sample_centre.sv
module sample_centre
    import tone_bpf_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 18
) (
    input  logic [IN_W-1:0]         raw,
    output logic signed [OUT_W-1:0] centred
);
    // flipping the top bit turns an offset-binary code into two's complement
    logic signed [IN_W-1:0] flipped;

    always_comb begin
        flipped = signed'({~raw[IN_W-1], raw[IN_W-2:0]});
        centred = OUT_W'(flipped);
    end
endmodule

// File: rtl/bp_section.sv
module bp_section
    import tone_bpf_pkg::*;
#(
    parameter int W    = 18,
    parameter int GAIN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  role_e               role,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] y_now,
    output logic signed [W-1:0] y_q
);
    localparam int AW = W + HEADROOM;
    localparam logic signed [AW-1:0] K_FF   = AW'(GAIN);
    localparam logic signed [AW-1:0] K_LAG2 = AW'(FB_LAG2);

    typedef struct packed {
        logic signed [W-1:0] d1;
        logic signed [W-1:0] d2;
    } hist_t;

    hist_t in_h;
    hist_t out_h;

    logic signed [AW-1:0] k_lag1;
    logic signed [AW-1:0] diff;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;

    always_comb begin
        k_lag1 = AW'(lag1_weight(role));
        diff   = AW'(din) - AW'(in_h.d2);
        acc    = K_FF * diff + k_lag1 * AW'(out_h.d1) + K_LAG2 * AW'(out_h.d2);
        scaled = acc >>> SCALE_SH;
        y_now  = scaled[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_h  <= '0;
            out_h <= '0;
        end else if (stb) begin
            in_h.d2  <= in_h.d1;
            in_h.d1  <= din;
            out_h.d2 <= out_h.d1;
            out_h.d1 <= y_now;
        end
    end

    assign y_q = out_h.d1;
endmodule

// File: rtl/sign_slicer.sv
module sign_slicer #(
    parameter int W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic signed [W-1:0] value,
    output logic                bit_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b1;
        end else if (stb) begin
            bit_q <= (value >= 0);
        end
    end
endmodule

// File: rtl/tone_prefilter.sv
module tone_prefilter
    import tone_bpf_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int ACC_W = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_stb,
    input  logic [IN_W-1:0]         smp_raw,
    input  logic                    role_orig,
    output logic                    bit_out,
    output logic signed [ACC_W-1:0] filt_out
);
    role_e role;
    logic signed [ACC_W-1:0] chain [NUM_SECT+1];
    logic signed [ACC_W-1:0] held  [NUM_SECT];

    assign role = role_e'(role_orig);

    sample_centre #(
        .IN_W (IN_W),
        .OUT_W(ACC_W)
    ) u_centre (
        .raw    (smp_raw),
        .centred(chain[0])
    );

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        bp_section #(
            .W   (ACC_W),
            .GAIN(sect_gain(s))
        ) u_sect (
            .clk  (clk),
            .rst  (rst),
            .stb  (smp_stb),
            .role (role),
            .din  (chain[s]),
            .y_now(chain[s+1]),
            .y_q  (held[s])
        );
    end

    sign_slicer #(
        .W(ACC_W)
    ) u_slice (
        .clk  (clk),
        .rst  (rst),
        .stb  (smp_stb),
        .value(chain[NUM_SECT]),
        .bit_q(bit_out)
    );

    assign filt_out = held[NUM_SECT-1];
endmodule

// File: rtl/tone_prefilter_chk.sv
module tone_prefilter_chk #(
    parameter int IN_W  = 8,
    parameter int ACC_W = 18
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_stb,
    input logic [IN_W-1:0]         smp_raw,
    input logic                    bit_out,
    input logic signed [ACC_W-1:0] filt_out
);
    // response of the cascade to one sample when every history is empty
    function automatic int first_resp(input logic [IN_W-1:0] r);
        int c;
        int a;
        int b;
        c = int'(r) - (1 << (IN_W - 1));
        a = (8 * c) >>> 3;
        b = (3 * a) >>> 3;
        return (2 * b) >>> 3;
    endfunction

    // R5: slicer bit tracks the sign of the registered filter value
    a_r5_sign_match: assert property (@(posedge clk) disable iff (rst)
        bit_out == (filt_out >= 0));

    // R6: no strobe, no change
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(filt_out) && $stable(bit_out)));

    // R8: cleared values visible right after reset releases
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (filt_out == '0 && bit_out));

    // R1: first strobe out of reset yields the closed-form cascade response
    a_r1_first_step: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && smp_stb) |=> (int'(filt_out) == first_resp($past(smp_raw))));
endmodule

bind tone_prefilter tone_prefilter_chk #(
    .IN_W (IN_W),
    .ACC_W(ACC_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_stb (smp_stb),
    .smp_raw (smp_raw),
    .bit_out (bit_out),
    .filt_out(filt_out)
);

// File: tb/sim_tone_prefilter.sv
module sim_tone_prefilter;
    localparam int IN_W  = 8;
    localparam int ACC_W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_stb = 1'b0;
    logic [IN_W-1:0] smp_raw = '0;
    logic role_orig = 1'b0;
    logic bit_out;
    logic signed [ACC_W-1:0] filt_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // reference state
    int m_in1 [3];
    int m_in2 [3];
    int m_y1  [3];
    int m_y2  [3];
    int m_out;

    tone_prefilter #(.IN_W(IN_W), .ACC_W(ACC_W)) u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_raw(smp_raw),
        .role_orig(role_orig), .bit_out(bit_out), .filt_out(filt_out)
    );

    always #2 clk = ~clk;

    function automatic int gain_of(input int s);
        return (s == 0) ? 8 : ((s == 1) ? 3 : 2);
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 3; s++) begin
            m_in1[s] = 0; m_in2[s] = 0; m_y1[s] = 0; m_y2[s] = 0;
        end
        m_out = 0;
    endtask

    task automatic model_step(input int raw, input bit orig);
        int u;
        int acc;
        int y;
        u = raw - 128;                                   // R1
        for (int s = 0; s < 3; s++) begin
            acc = gain_of(s) * (u - m_in2[s])            // R2
                + (orig ? -1 : 7) * m_y1[s] - 4 * m_y2[s];  // R3 / R4
            y = acc >>> 3;
            m_in2[s] = m_in1[s]; m_in1[s] = u;
            m_y2[s]  = m_y1[s];  m_y1[s]  = y;
            u = y;
        end
        m_out = u;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one strobe, compare after the capturing edge (R9)
    task automatic strobe(input int raw, input bit orig, input string tag);
        @(negedge clk);
        smp_stb = 1'b1; smp_raw = IN_W'(raw); role_orig = orig;
        @(negedge clk);
        smp_stb = 1'b0;
        model_step(raw, orig);
        chk(tag, int'(filt_out), m_out);
        chk("R5", int'(bit_out), (m_out >= 0) ? 1 : 0);
    endtask

    // R6: wiggle inputs with no strobe; outputs must hold
    task automatic idle_gap(input int n);
        int f0;
        int b0;
        f0 = int'(filt_out); b0 = int'(bit_out);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_raw = IN_W'($urandom_range(0, 255));
            role_orig = $urandom_range(0, 1) != 0;
        end
        @(negedge clk);
        chk("R6 filt", int'(filt_out), f0);
        chk("R6 bit", int'(bit_out), b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_clear();
        chk("R8 filt", int'(filt_out), 0);
        chk("R8 bit", int'(bit_out), 1);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        bit orig;
        void'($urandom(32'd20170220));
        model_clear();
        do_reset();

        // R1: first step from empty history, full-scale low sample
        strobe(0, 1'b0, "R1");
        do_reset();
        strobe(255, 1'b0, "R1");
        // R2 / R3: impulse response ringing in the answer role
        for (int i = 0; i < 20; i++) strobe(128, 1'b0, "R3");
        do_reset();
        // R4: impulse response in the originate role
        strobe(200, 1'b1, "R4");
        for (int i = 0; i < 20; i++) strobe(128, 1'b1, "R4");

        // R2: square tone near each passband, extremes 0 / 255
        do_reset();
        for (int i = 0; i < 60; i++) strobe(((i / 3) % 2) ? 255 : 0, 1'b0, "R3");
        for (int i = 0; i < 60; i++) strobe(((i / 2) % 2) ? 255 : 0, 1'b1, "R4");

        // R7: role flips mid-stream, history kept
        for (int i = 0; i < 10; i++) strobe(128 + 60 * ((i % 4) - 1), 1'b0, "R3");
        strobe(10, 1'b1, "R7");
        strobe(240, 1'b1, "R7");
        strobe(30, 1'b0, "R7");

        // R6: ignored inputs between strobes, then history intact
        idle_gap(5);
        strobe(77, 1'b0, "R6");

        // random stream with gaps and occasional role flips
        orig = 1'b0;
        for (int i = 0; i < 800; i++) begin
            if ($urandom_range(0, 15) == 0) orig = ~orig;
            strobe($urandom_range(0, 255), orig, orig ? "R4" : "R3");
            if ($urandom_range(0, 3) == 0) idle_gap($urandom_range(1, 4));
        end

        // R8: reset in mid-run clears all sections
        do_reset();
        strobe(128, 1'b0, "R8");
        strobe(129, 1'b0, "R8");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule